// File: doc/BRIEF.md
# Lockstep Twin Counter Cross-Check

This block models two copies of the same circuit running side by side on one clock. Each side owns a free-running counter. Each side exports a registered copy of its count to the other side. Each side keeps an identically delayed copy of its own count for comparison. A comparator on each side checks its own delayed count against the copy that arrived from the other side. The comparator publishes a fixed status byte: zero when the two agree, three when they do not.

A shared saturating tally counts every cycle in which either comparator reports something other than zero. One synchronous reset clears both sides together, so the two counts run in step from the first cycle. There is no handshake between the sides.

A per-side skip input makes that side's counter hold for one cycle instead of advancing. This lets a test deliberately break the lockstep and watch the comparators and the tally react.

Top module: `dual_vote_top`

## Requirements
- R1: While `rst` is sampled high on a rising edge, every output is zero after that edge.
- R2: With its skip input low, each counter advances by exactly one per clock. With no skip applied since reset, `count_a` equals `count_b` in every cycle.
- R3: A counter at 0xFFFF moves to 0x0000 on its next advancing clock.
- R4: Each comparator output is 0x00 when the two aligned counts agree and 0x03 when they differ. The code reflects the counts two clocks after they appear on `count_a`/`count_b`: one clock for the crossing register and one for the comparator register.
- R5: The two comparators use identical logic, so `vote_a` equals `vote_b` in every cycle.
- R6: `err_count` rises by one on the clock after a cycle in which either code is nonzero. It holds its value on the clock after a cycle in which both codes are zero.
- R7: `err_count` saturates at 0xFF and stays there until reset.
- R8: A high `inj_skip_a` (or `inj_skip_b`) on a rising edge makes that counter keep its value across that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both sides |
| rst | input | 1 | Synchronous active-high reset shared by both sides |
| inj_skip_a | input | 1 | Hold side A's counter for this cycle (fault injection) |
| inj_skip_b | input | 1 | Hold side B's counter for this cycle (fault injection) |
| count_a | output | 16 | Side A counter value |
| count_b | output | 16 | Side B counter value |
| vote_a | output | 8 | Side A comparator code (0x00 agree, 0x03 differ) |
| vote_b | output | 8 | Side B comparator code (0x00 agree, 0x03 differ) |
| err_count | output | 8 | Saturating count of cycles with a nonzero code |

## Verification
The latencies are fixed.
- A skip shows on the counts right after the edge where it is sampled.
- The comparator codes change two edges after the counts diverge.
- The tally moves one edge after that, so three edges after the divergence.

The bench drives inputs and samples outputs on the falling edge, and steps a counted number of edges between stimulus and check. This puts each expectation on the exact cycle where the result is due, including the cycles just before the code changes. A skip on one side followed five edges later by a skip on the other side must therefore leave a tally of exactly five.

// File: rtl/dual_vote_pkg.sv
package dual_vote_pkg;
    parameter int unsigned VOTE_CODE_W = 8;
    typedef logic [VOTE_CODE_W-1:0] vote_code_t;
    localparam vote_code_t VOTE_AGREE  = vote_code_t'(8'h00);
    localparam vote_code_t VOTE_DIFFER = vote_code_t'(8'h03);
endpackage

// File: rtl/dv_counter.sv
module dv_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             skip,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] link
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] tx;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.tx = st_q.cnt;
        if (!skip) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign link  = st_q.tx;
endmodule

// File: rtl/dv_voter.sv
module dv_voter
    import dual_vote_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] own_link,
    input  logic [CNT_W-1:0] far_link,
    output vote_code_t       code
);
    typedef struct packed {
        vote_code_t code;
    } vote_state_t;

    vote_state_t st_d, st_q;

    always_comb begin
        st_d.code = (own_link != far_link) ? VOTE_DIFFER : VOTE_AGREE;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign code = st_q.code;
endmodule

// File: rtl/dv_tally.sv
module dv_tally
    import dual_vote_pkg::*;
#(
    parameter int unsigned ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  vote_code_t       code_a,
    input  vote_code_t       code_b,
    output logic [ERR_W-1:0] tally
);
    localparam logic [ERR_W-1:0] TALLY_MAX = '1;

    typedef struct packed {
        logic [ERR_W-1:0] cnt;
    } tally_state_t;

    tally_state_t st_d, st_q;
    logic         flagged;

    always_comb begin
        flagged = (code_a != VOTE_AGREE) || (code_b != VOTE_AGREE);
        st_d    = st_q;
        if (flagged && (st_q.cnt != TALLY_MAX)) begin
            st_d.cnt = st_q.cnt + ERR_W'(1);
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign tally = st_q.cnt;
endmodule

// File: rtl/dual_vote_top.sv
module dual_vote_top
    import dual_vote_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inj_skip_a,
    input  logic             inj_skip_b,
    output logic [CNT_W-1:0] count_a,
    output logic [CNT_W-1:0] count_b,
    output logic [7:0]       vote_a,
    output logic [7:0]       vote_b,
    output logic [ERR_W-1:0] err_count
);
    localparam int unsigned SIDES = 2;

    logic [SIDES-1:0] skip_v;
    logic [CNT_W-1:0] cnt_v  [SIDES];
    logic [CNT_W-1:0] link_v [SIDES];
    vote_code_t       code_v [SIDES];

    assign skip_v = {inj_skip_b, inj_skip_a};

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        dv_counter #(.CNT_W(CNT_W)) i_ctr (
            .clk   (clk),
            .rst   (rst),
            .skip  (skip_v[s]),
            .count (cnt_v[s]),
            .link  (link_v[s])
        );

        dv_voter #(.CNT_W(CNT_W)) i_vote (
            .clk      (clk),
            .rst      (rst),
            .own_link (link_v[s]),
            .far_link (link_v[SIDES-1-s]),
            .code     (code_v[s])
        );
    end

    dv_tally #(.ERR_W(ERR_W)) i_tally (
        .clk    (clk),
        .rst    (rst),
        .code_a (code_v[0]),
        .code_b (code_v[1]),
        .tally  (err_count)
    );

    assign count_a = cnt_v[0];
    assign count_b = cnt_v[1];
    assign vote_a  = code_v[0];
    assign vote_b  = code_v[1];
endmodule

// File: rtl/dv_checker.sv
module dv_checker #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned ERR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             inj_skip_a,
    input logic             inj_skip_b,
    input logic [CNT_W-1:0] count_a,
    input logic [CNT_W-1:0] count_b,
    input logic [7:0]       vote_a,
    input logic [7:0]       vote_b,
    input logic [ERR_W-1:0] err_count
);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    assert_step_a_R2: assert property (@(posedge clk) disable iff (rst)
        !inj_skip_a |=> count_a == CNT_W'($past(count_a) + 1'b1));
    assert_step_b_R2: assert property (@(posedge clk) disable iff (rst)
        !inj_skip_b |=> count_b == CNT_W'($past(count_b) + 1'b1));
    assert_hold_a_R8: assert property (@(posedge clk) disable iff (rst)
        inj_skip_a |=> $stable(count_a));
    assert_hold_b_R8: assert property (@(posedge clk) disable iff (rst)
        inj_skip_b |=> $stable(count_b));
    assert_code_set_R4: assert property (@(posedge clk) disable iff (rst)
        vote_a == 8'h00 || vote_a == 8'h03);
    assert_differ_R4: assert property (@(posedge clk) disable iff (rst)
        count_a != count_b |=> ##1 vote_a == 8'h03);
    assert_agree_R4: assert property (@(posedge clk) disable iff (rst)
        count_a == count_b |=> ##1 vote_a == 8'h00);
    assert_twin_R5: assert property (@(posedge clk) disable iff (rst)
        vote_a == vote_b);
    assert_tally_up_R6: assert property (@(posedge clk) disable iff (rst)
        (vote_a != 8'h00 || vote_b != 8'h00) && err_count != ERR_MAX
        |=> err_count == ERR_W'($past(err_count) + 1'b1));
    assert_tally_hold_R6: assert property (@(posedge clk) disable iff (rst)
        vote_a == 8'h00 && vote_b == 8'h00 |=> $stable(err_count));
    assert_saturate_R7: assert property (@(posedge clk) disable iff (rst)
        err_count == ERR_MAX |=> err_count == ERR_MAX);
endmodule

bind dual_vote_top dv_checker #(.CNT_W(CNT_W), .ERR_W(ERR_W)) i_dv_checker (
    .clk        (clk),
    .rst        (rst),
    .inj_skip_a (inj_skip_a),
    .inj_skip_b (inj_skip_b),
    .count_a    (count_a),
    .count_b    (count_b),
    .vote_a     (vote_a),
    .vote_b     (vote_b),
    .err_count  (err_count)
);

// File: tb/test_dual_vote_top.sv
module test_dual_vote_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        inj_skip_a = 1'b0;
    logic        inj_skip_b = 1'b0;
    logic [15:0] count_a, count_b;
    logic [7:0]  vote_a, vote_b;
    logic [7:0]  err_count;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    dual_vote_top i_dual_vote_top (
        .clk        (clk),
        .rst        (rst),
        .inj_skip_a (inj_skip_a),
        .inj_skip_b (inj_skip_b),
        .count_a    (count_a),
        .count_b    (count_b),
        .vote_a     (vote_a),
        .vote_b     (vote_b),
        .err_count  (err_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        inj_skip_a = 1'b0;
        inj_skip_b = 1'b0;
        step(3);
        check("R1 count_a", 32'(count_a), 0);
        check("R1 count_b", 32'(count_b), 0);
        check("R1 vote_a", 32'(vote_a), 0);
        check("R1 vote_b", 32'(vote_b), 0);
        check("R1 err_count", 32'(err_count), 0);
        rst = 1'b0;
    endtask

    task automatic t_count();
        t_reset();
        step(37);
        check("R2 count_a", 32'(count_a), 37);
        check("R2 count_b", 32'(count_b), 37);
        check("R4 vote_a agree", 32'(vote_a), 0);
        check("R6 err_count idle", 32'(err_count), 0);
    endtask

    task automatic t_skip_realign();
        t_reset();
        step(10);
        inj_skip_a = 1'b1;
        step(1);
        inj_skip_a = 1'b0;
        check("R8 count_a held", 32'(count_a), 10);
        check("R8 count_b ran", 32'(count_b), 11);
        check("R4 vote_a before due", 32'(vote_a), 0);
        step(1);
        check("R4 vote_a one edge later", 32'(vote_a), 0);
        step(1);
        check("R4 vote_a differ due", 32'(vote_a), 8'h03);
        check("R5 vote_b twin", 32'(vote_b), 8'h03);
        step(2);
        inj_skip_b = 1'b1;
        step(1);
        inj_skip_b = 1'b0;
        check("R8 count_b held realign", 32'(count_b), 32'(count_a));
        step(4);
        check("R4 vote_a agree again", 32'(vote_a), 0);
        check("R6 err_count five", 32'(err_count), 5);
        step(20);
        check("R6 err_count holds", 32'(err_count), 5);
    endtask

    task automatic t_saturate();
        t_reset();
        step(4);
        inj_skip_b = 1'b1;
        step(1);
        inj_skip_b = 1'b0;
        step(300);
        check("R7 err_count saturated", 32'(err_count), 8'hFF);
        check("R5 vote_b persistent", 32'(vote_b), 8'h03);
        step(10);
        check("R7 err_count stays", 32'(err_count), 8'hFF);
        t_reset();
    endtask

    task automatic t_wrap();
        t_reset();
        step(65535);
        check("R3 count_a top", 32'(count_a), 16'hFFFF);
        step(1);
        check("R3 count_a wrapped", 32'(count_a), 0);
        check("R3 count_b wrapped", 32'(count_b), 0);
        step(1);
        check("R3 count_a after wrap", 32'(count_a), 1);
        step(2);
        check("R4 vote_a across wrap", 32'(vote_a), 0);
        check("R6 err_count across wrap", 32'(err_count), 0);
    endtask

    initial begin
        @(negedge clk);
        t_count();
        t_skip_realign();
        t_saturate();
        t_wrap();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog (R1..R8 run): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule